// File: doc/BRIEF.md
# Flash Block-Erase Command Controller

This block is the command interface and write sequencer for a small NOR-style flash array held in on-chip registers. Software reaches it through simple bus writes, each carrying an address and a command or data byte. A combinational read port returns either an array word or the 8-bit status register, depending on the current read mode. The supported commands are erase setup and confirm, erase suspend and resume, word program, clear-status and read-array.

A block erase runs as three timed phases, each `PHASE_CYC` cycles long. The first phase drives every bit of the block to 0, the second drives every bit back to 1, and the third checks that the whole block reads erased. A suspend request takes effect only at a phase boundary. While the erase is suspended, words in any other block can be programmed and read. A programming-voltage-valid input is sampled at confirm time and at program time; when it is low, the operation is refused and the fault is reported in the status register. A fault-injection input forces the verify phase to fail, so the error path can be exercised.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the controller is in read-array mode, every array word reads all ones, and the status register reads 80h (ready, no errors).
- R2: Writing 20h and then D0h starts an erase of the block addressed by the D0h write. When the erase completes, every word of that block reads all ones, other blocks keep their data, and the status register reads 80h.
- R3: A block erase keeps status bit 7 at 0 for exactly 3*PHASE_CYC cycles after the confirm write. Status bit 7 is 1 again from then on.
- R4: When the verify phase fails (which happens whenever fail injection is high), the erase finishes with status bit 5 set and status bit 7 at 1.
- R5: If the voltage-valid input is low when D0h confirms an erase, no erase phase runs, the block data stay unchanged, and status bits 5 and 3 are set at once with bit 7 at 1.
- R6: Command 50h clears status bits 5, 4 and 3 and leaves the read mode unchanged.
- R7: Writing B0h during an erase suspends it at the next phase boundary. While suspended, the status register reads C0h (bits 7 and 6 set).
- R8: While an erase is suspended, words in other blocks can be programmed and read. A read of the suspended block returns the status register. Issuing 20h instead sets status bits 5 and 4 and does not start a second erase.
- R9: A program that targets the suspended block sets status bit 4 and leaves the array unchanged.
- R10: D0h resumes a suspended erase from any address, clearing status bits 6 and 2 and bringing bit 7 to 0. The erase then needs 2*PHASE_CYC more cycles when it was suspended after its first phase. While a nested program is still busy, D0h is ignored.
- R11: After 20h, 40h or D0h, reads return the status register. After FFh, reads return array words.
- R12: An unrecognised command byte, or D0h written with no pending setup, sets status bits 5 and 4 and leaves the controller idle.
- R13: Writing 40h and then a data word programs the addressed word to (old AND data). Status bit 7 stays 0 for PROG_CYC cycles after the data write.
- R14: While an erase or program runs, every write except B0h during an erase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | log2(NBLK*WPB) | Word address for writes and reads; the upper bits select the block |
| bus_wdata | input | DW | Command byte (low 8 bits) or program data |
| bus_rdata | output | DW | Array word or status register, selected by the read mode |
| vpp_ok | input | 1 | Programming voltage is within limits |
| inj_fail | input | 1 | Forces the erase verify phase to fail |

## Verification
The erase is exercised in four runs: a plain erase, an erase that is suspended after its first phase and resumed from an address in another block, an erase with fail injection, and an erase confirmed with the voltage input low. Cycle counts of the busy time separate a correct phase sequence from one that is too short, too long, or suspended away from a boundary. Reads of blocks that were programmed beforehand show whether only the captured block was erased. During the suspend, nested programs are sent both to a free block and to the suspended block, and a resume is sent while a nested program is still busy; this tells an accepted operation from one that is refused or ignored.

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int NBLK      = 4,
  parameter int WPB       = 8,
  parameter int DW        = 8,
  parameter int PHASE_CYC = 6,
  parameter int PROG_CYC  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_we,
  input  logic [$clog2(NBLK*WPB)-1:0]     bus_addr,
  input  logic [DW-1:0]                   bus_wdata,
  output logic [DW-1:0]                   bus_rdata,
  input  logic                            vpp_ok,
  input  logic                            inj_fail
);
  localparam int NW   = NBLK * WPB;
  localparam int AW   = $clog2(NW);
  localparam int BW   = $clog2(NBLK);
  localparam int OW   = $clog2(WPB);
  localparam int CMAX = (PHASE_CYC > PROG_CYC) ? PHASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {W_IDLE, W_ERASE, W_SUSP, W_PROG, W_SPROG} wsm_t;
  typedef enum logic [1:0] {C_IDLE, C_ESET, C_PSET} cui_t;

  wsm_t            wsm;
  cui_t            cui;
  logic [DW-1:0]   mem [NW];
  logic [1:0]      ph;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   sblk;
  logic [AW-1:0]   paddr;
  logic [DW-1:0]   pdata;
  logic            susp_req, mode_arr, e5, e4, e3;
  logic            blk_ok;
  logic [7:0]      status;

  wire [7:0]    cmd    = bus_wdata[7:0];
  wire [BW-1:0] ablk   = bus_addr[AW-1 -: BW];
  wire          ready  = (wsm == W_IDLE) || (wsm == W_SUSP);
  wire          susp   = (wsm == W_SUSP) || (wsm == W_SPROG);
  wire          accept = bus_we && ready;
  wire          ph_end = (cnt == CW'(PHASE_CYC - 1));
  wire          pr_end = (cnt == CW'(PROG_CYC - 1));

  assign status = {ready, susp, e5, e4, e3, 3'b000};

  always_comb begin
    blk_ok = 1'b1;
    for (int i = 0; i < WPB; i++)
      if (mem[{sblk, OW'(i)}] != '1) blk_ok = 1'b0;
  end

  always_comb begin
    if (mode_arr && !(susp && ablk == sblk)) bus_rdata = mem[bus_addr];
    else                                     bus_rdata = DW'(status);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsm <= W_IDLE;
      cui <= C_IDLE;
      ph <= '0;
      cnt <= '0;
      sblk <= '0;
      paddr <= '0;
      pdata <= '0;
      susp_req <= 1'b0;
      mode_arr <= 1'b1;
      e5 <= 1'b0;
      e4 <= 1'b0;
      e3 <= 1'b0;
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else begin
      case (wsm)
        W_ERASE: begin
          if (ph_end) begin
            cnt <= '0;
            case (ph)
              2'd0: for (int i = 0; i < WPB; i++) mem[{sblk, OW'(i)}] <= '0;
              2'd1: for (int i = 0; i < WPB; i++) mem[{sblk, OW'(i)}] <= '1;
              default: ;
            endcase
            if (ph == 2'd2) begin
              if (inj_fail || !blk_ok) e5 <= 1'b1;
              wsm <= W_IDLE;
              ph <= '0;
              susp_req <= 1'b0;
            end else begin
              ph <= ph + 2'd1;
              if (susp_req) begin
                wsm <= W_SUSP;
                susp_req <= 1'b0;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (bus_we && cmd == 8'hB0) susp_req <= 1'b1;
        end
        W_PROG, W_SPROG: begin
          if (pr_end) begin
            mem[paddr] <= mem[paddr] & pdata;
            cnt <= '0;
            wsm <= (wsm == W_SPROG) ? W_SUSP : W_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase

      if (accept) begin
        case (cui)
          C_ESET: begin
            cui <= C_IDLE;
            if (cmd != 8'hD0) begin
              e5 <= 1'b1;
              e4 <= 1'b1;
            end else if (!vpp_ok) begin
              e5 <= 1'b1;
              e3 <= 1'b1;
            end else begin
              sblk <= ablk;
              wsm <= W_ERASE;
              ph <= '0;
              cnt <= '0;
            end
          end
          C_PSET: begin
            cui <= C_IDLE;
            if (susp && ablk == sblk) begin
              e4 <= 1'b1;
            end else if (!vpp_ok) begin
              e4 <= 1'b1;
              e3 <= 1'b1;
            end else begin
              paddr <= bus_addr;
              pdata <= bus_wdata;
              cnt <= '0;
              wsm <= susp ? W_SPROG : W_PROG;
            end
          end
          default: begin
            case (cmd)
              8'h20: begin
                mode_arr <= 1'b0;
                if (susp) begin
                  e5 <= 1'b1;
                  e4 <= 1'b1;
                end else begin
                  cui <= C_ESET;
                end
              end
              8'h40: begin
                mode_arr <= 1'b0;
                cui <= C_PSET;
              end
              8'h50: begin
                e5 <= 1'b0;
                e4 <= 1'b0;
                e3 <= 1'b0;
              end
              8'hFF: mode_arr <= 1'b1;
              8'hD0: begin
                if (susp) begin
                  wsm <= W_ERASE;
                  mode_arr <= 1'b0;
                  susp_req <= 1'b0;
                end else begin
                  e5 <= 1'b1;
                  e4 <= 1'b1;
                end
              end
              8'hB0: ;
              default: begin
                e5 <= 1'b1;
                e4 <= 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

module flash_erase_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [7:0] wcmd,
  input logic       vpp_ok,
  input logic [7:0] status,
  input logic [1:0] cui_st
);
  wire wr_ok = bus_we && status[7];

  a_r5_vpp_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cui_st == 2'd1 && wcmd == 8'hD0 && !vpp_ok) |=> (status[7] && status[5] && status[3]));

  a_r12_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cui_st == 2'd0 && !(wcmd inside {8'h20, 8'h40, 8'h50, 8'hFF, 8'hD0, 8'hB0}))
      |=> (status[5] && status[4]));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cui_st == 2'd0 && wcmd == 8'h50) |=> (status[5:3] == 3'b000));

  a_r10_resume_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !status[7]) |=> status[6]);

  a_r7_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> status[7]);
endmodule

bind flash_erase_ctl flash_erase_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .wcmd(bus_wdata[7:0]),
  .vpp_ok(vpp_ok), .status(status), .cui_st(cui)
);

// File: tb/flash_erase_ctl_bench.sv
module flash_erase_ctl_bench;
  localparam int CLK_P = 10;
  localparam int NBLK = 4, WPB = 8, DW = 8, PH = 6, PG = 3;
  localparam int AW = $clog2(NBLK * WPB);

  logic clk = 0, rst_n = 0, bus_we = 0, vpp_ok = 1, inj_fail = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int addr; logic [7:0] exp; logic [7:0] mask; string tag; } item_t;
  item_t sbq[$];

  always #(CLK_P/2) clk = ~clk;

  flash_erase_ctl #(.NBLK(NBLK), .WPB(WPB), .DW(DW), .PHASE_CYC(PH), .PROG_CYC(PG)) u_flash_erase_ctl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .vpp_ok(vpp_ok), .inj_fail(inj_fail));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (sbq.size() > 0) begin
      item_t it = sbq.pop_front();
      chk((bus_rdata & it.mask) == (it.exp & it.mask), it.tag, bus_rdata & it.mask, it.exp & it.mask);
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_exp(input int a, input logic [7:0] e, input string tag, input logic [7:0] m = 8'hFF);
    bus_addr = AW'(a);
    sbq.push_back('{a, e, m, tag});
    @(negedge clk);
  endtask

  task automatic wait_rdy(input int start, output int n);
    n = start;
    while (!bus_rdata[7] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic prog(input int a, input logic [7:0] d, input string tag);
    int n;
    wr(a, 8'h40);
    wr(a, d);
    wait_rdy(0, n);
    chk(n == PG, tag, n, PG);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_exp(5, 8'hFF, "R1 array after reset");
    wr(0, 8'h50);
    rd_exp(30, 8'hFF, "R1 read mode array");

    prog(10, 8'h3C, "R13 program busy time");
    rd_exp(10, 8'h80, "R11 status after program");
    wr(0, 8'hFF);
    rd_exp(10, 8'h3C, "R13 programmed word");
    prog(10, 8'h0F, "R13 second program busy time");
    wr(0, 8'hFF);
    rd_exp(10, 8'h0C, "R13 AND of old and new");
    prog(3, 8'h00, "R13 program block0");

    wr(0, 8'h20);
    rd_exp(0, 8'h80, "R11 status after setup");
    wr(13, 8'hD0);
    wait_rdy(0, n);
    chk(n == 3 * PH, "R3 erase busy time", n, 3 * PH);
    rd_exp(0, 8'h80, "R2 status after erase");
    wr(0, 8'hFF);
    rd_exp(10, 8'hFF, "R2 erased word");
    rd_exp(3, 8'h00, "R2 other block untouched");

    wr(0, 8'h20);
    wr(2, 8'hD0);
    wr(0, 8'hFF);
    wr(0, 8'h12);
    wait_rdy(2, n);
    chk(n == 3 * PH, "R14 erase time with writes", n, 3 * PH);
    rd_exp(3, 8'h80, "R14 busy writes ignored");
    wr(0, 8'hFF);
    rd_exp(3, 8'hFF, "R2 block0 erased");

    inj_fail = 1;
    wr(0, 8'h20);
    wr(20, 8'hD0);
    wait_rdy(0, n);
    inj_fail = 0;
    rd_exp(0, 8'hA0, "R4 verify failure");
    wr(0, 8'h50);
    rd_exp(0, 8'h80, "R6 clear keeps status mode");

    prog(17, 8'h55, "R13 program block2");
    vpp_ok = 0;
    wr(0, 8'h20);
    wr(17, 8'hD0);
    rd_exp(17, 8'hA8, "R5 voltage fault status");
    vpp_ok = 1;
    wr(0, 8'hFF);
    rd_exp(17, 8'h55, "R5 data unchanged");
    wr(0, 8'h50);
    rd_exp(17, 8'h55, "R6 clear keeps array mode");

    wr(0, 8'h20);
    wr(0, 8'h12);
    rd_exp(0, 8'hB0, "R12 setup then bad confirm");
    wr(0, 8'h50);
    wr(0, 8'hD0);
    rd_exp(0, 8'hB0, "R12 confirm without setup");
    wr(0, 8'h50);
    wr(0, 8'h7E);
    rd_exp(0, 8'hB0, "R12 unknown command");
    wr(0, 8'h50);

    prog(24, 8'h00, "R13 program block3");
    prog(8, 8'h00, "R13 program block1");
    wr(0, 8'h20);
    wr(8, 8'hD0);
    wr(0, 8'hB0);
    wait_rdy(1, n);
    chk(n == PH, "R7 suspend at phase boundary", n, PH);
    rd_exp(0, 8'hC0, "R7 suspended status");
    wr(0, 8'hFF);
    rd_exp(24, 8'h00, "R8 read other block");
    rd_exp(8, 8'hC0, "R8 suspended block reads status");
    wr(9, 8'h40);
    wr(9, 8'h00);
    rd_exp(9, 8'hD0, "R9 program into suspended block");
    wr(0, 8'h50);
    wr(0, 8'h20);
    rd_exp(0, 8'hF0, "R8 second erase refused");
    wr(0, 8'h50);
    wr(25, 8'h40);
    wr(25, 8'h81);
    wr(30, 8'hD0);
    wait_rdy(1, n);
    chk(n == PG, "R8 nested program time", n, PG);
    rd_exp(0, 8'hC0, "R10 resume ignored while busy");
    wr(0, 8'hFF);
    rd_exp(25, 8'h81, "R8 nested program result");
    wr(30, 8'hD0);
    rd_exp(0, 8'h00, "R10 resume clears bits 7 6 2", 8'hC4);
    wait_rdy(1, n);
    chk(n == 2 * PH, "R10 remaining erase time", n, 2 * PH);
    rd_exp(0, 8'h80, "R2 status after resumed erase");
    wr(0, 8'hFF);
    rd_exp(8, 8'hFF, "R2 resumed erase result");
    rd_exp(9, 8'hFF, "R9 block still erased");
    rd_exp(24, 8'h00, "R2 block3 untouched");
    rd_exp(25, 8'h81, "R2 nested data kept");
    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end
endmodule